// File: doc/BRIEF.md
# DRAM Access and Refresh Sequencer

This block sits between a requester and an asynchronous-style DRAM. The requester hands over a complete word address together with a write flag. The block then places the upper part of that address on a narrow shared address bus while it raises the row strobe. Next it places the lower part on the same bus while it raises the column strobe. When the access is over it returns a single-cycle completion pulse. The completion pulse marks the end of the access time as the requester sees it.

The memory does not refresh itself, so the block does that work. A free-running interval timer raises a refresh demand once every interval. That demand is served by a row-only cycle, in which the column strobe stays low and a row counter supplies the address. The counter moves on by one row after each refresh and wraps at the last row. The default interval is the 64 ms retention period divided by the number of rows, converted to clocks. At full size this gives a 21-bit address split into 12 row bits and 9 column bits. A pending refresh is always served ahead of a new request. A refresh that falls due during an access waits until that access has finished.

Top module: `dram_access_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards whenever `busy` is low, the outputs `rowStrobe`, `colStrobe`, `chipSel`, `memWrite` and `done` are all low.
- R2: A request is taken only in a cycle where the block is idle and no refresh is pending. A request pulse raised while `busy` is high has no effect: the access in progress keeps its own address, and no second access follows it.
- R3: An access starts in the cycle after the clock edge that takes the request. For T_RCD cycles, `rowStrobe` and `chipSel` are high, `colStrobe` is low, and `memAddr` carries the upper ROW_W address bits, `reqAddr[ADDR_W-1:COL_W]`.
- R4: In the T_CAS cycles that follow, `rowStrobe`, `colStrobe` and `chipSel` are high. `memAddr` carries the lower COL_W address bits, `reqAddr[COL_W-1:0]`, zero-extended, and it holds steady.
- R5: In the first cycle after the column phase, `done` is high for exactly one cycle, with every strobe low and `busy` high. `busy` falls T_RP cycles after the column phase ends.
- R6: `memWrite` equals the write flag that was taken with the request, for the whole row and column phases. It is low during refresh.
- R7: When the block is idle, a refresh cycle begins every REF_INTERVAL cycles. In a refresh cycle, `rowStrobe` and `chipSel` are high for T_REF cycles, `colStrobe` stays low, and T_RP cycles with every strobe low follow. A refresh cycle never raises `done`.
- R8: The first refresh after reset drives row 0 on `memAddr`. Each later refresh drives the next row, and row 2^ROW_W-1 is followed by row 0.
- R9: If a refresh is pending in the same cycle that a request arrives at an idle block, the refresh is done first. The request, held high by the requester, is taken after the refresh cycle.
- R10: A refresh that falls due during an access begins right after that access goes idle. It begins before any request raised in that idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Requester asks for an access |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqAddr | input | ROW_W+COL_W | Full word address |
| busy | output | 1 | High whenever the block is not idle |
| done | output | 1 | One-cycle completion pulse for an access |
| memAddr | output | max(ROW_W,COL_W) | Multiplexed row/column address to the DRAM |
| rowStrobe | output | 1 | Row address strobe, active high |
| colStrobe | output | 1 | Column address strobe, active high |
| memWrite | output | 1 | Write enable to the DRAM, active high |
| chipSel | output | 1 | DRAM select, active high |

## Verification
Once the edge that takes a request has passed, each phase has a fixed count of cycles. The row phase holds for T_RCD cycles and the column phase for the next T_CAS cycles. The `done` cycle comes after that, and `busy` falls T_RP cycles later. The bench drives inputs and samples outputs on falling edges, and it steps through those counts one falling edge at a time. Refresh is timed in the same way: the bench first lines up on an observed refresh start. It then waits an exact number of cycles, so that a request lands on the cycle before a refresh falls due, on the cycle it falls due, or in the middle of an access. It then checks which operation appears on the strobes in the next cycle.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_PRE,
    ST_REF
  } seqState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic latchReq;  // capture reqAddr / reqWrite
    logic selCol;    // drive column half
    logic selRef;    // drive refresh row counter
    logic takeRef;   // refresh demand consumed
    logic stepRow;   // advance refresh row counter
  } pathCtl_t;
endpackage

// File: rtl/dram_ctrl_path.sv
module dram_ctrl_path
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W        = 12,
  parameter int COL_W        = 9,
  parameter int REF_INTERVAL = 1953,
  localparam int ADDR_W      = ROW_W + COL_W,
  localparam int MUX_W       = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int TMR_W       = $clog2(REF_INTERVAL)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  output logic [MUX_W-1:0]  memAddr,
  output logic              heldWrite,
  output logic              refPending
);
  logic [ADDR_W-1:0] addrReg;
  logic [ROW_W-1:0]  refRow;
  logic [TMR_W-1:0]  refTimer;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      heldWrite <= 1'b0;
    end else if (ctl.latchReq) begin
      addrReg   <= reqAddr;
      heldWrite <= reqWrite;
    end
  end

  // Interval timer: one refresh demand every REF_INTERVAL clocks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refTimer   <= TMR_W'(REF_INTERVAL - 1);
      refPending <= 1'b0;
    end else begin
      if (refTimer == '0) refTimer <= TMR_W'(REF_INTERVAL - 1);
      else                refTimer <= refTimer - 1'b1;
      if (refTimer == '0)   refPending <= 1'b1;
      else if (ctl.takeRef) refPending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            refRow <= '0;
    else if (ctl.stepRow) refRow <= refRow + 1'b1;
  end

  always_comb begin
    if (ctl.selRef)      memAddr = MUX_W'(refRow);
    else if (ctl.selCol) memAddr = MUX_W'(addrReg[COL_W-1:0]);
    else                 memAddr = MUX_W'(addrReg[ADDR_W-1:COL_W]);
  end
endmodule

// File: rtl/dram_ctrl_fsm.sv
module dram_ctrl_fsm
  import dram_ctrl_pkg::*;
#(
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_RP  = 1,
  parameter int T_REF = 3,
  localparam int MAX_A = (T_RCD > T_CAS) ? T_RCD : T_CAS,
  localparam int MAX_B = (T_RP > T_REF) ? T_RP : T_REF,
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B,
  localparam int CNT_W = $clog2(MAX_T + 1)
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     refPending,
  input  logic     heldWrite,
  output pathCtl_t ctl,
  output logic     busy,
  output logic     done,
  output logic     rowStrobe,
  output logic     colStrobe,
  output logic     memWrite,
  output logic     chipSel
);
  seqState_t        state;
  logic [CNT_W-1:0] phaseCnt;
  logic             doneReg;
  logic             phaseEnd;

  assign phaseEnd = (phaseCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (refPending) begin
            state    <= ST_REF;
            phaseCnt <= CNT_W'(T_REF - 1);
          end else if (reqValid) begin
            state    <= ST_ROW;
            phaseCnt <= CNT_W'(T_RCD - 1);
          end
        end
        ST_ROW: begin
          if (phaseEnd) begin
            state    <= ST_COL;
            phaseCnt <= CNT_W'(T_CAS - 1);
          end else phaseCnt <= phaseCnt - 1'b1;
        end
        ST_COL: begin
          if (phaseEnd) begin
            state    <= ST_PRE;
            phaseCnt <= CNT_W'(T_RP - 1);
            doneReg  <= 1'b1;
          end else phaseCnt <= phaseCnt - 1'b1;
        end
        ST_REF: begin
          if (phaseEnd) begin
            state    <= ST_PRE;
            phaseCnt <= CNT_W'(T_RP - 1);
          end else phaseCnt <= phaseCnt - 1'b1;
        end
        ST_PRE: begin
          if (phaseEnd) state <= ST_IDLE;
          else          phaseCnt <= phaseCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.latchReq = (state == ST_IDLE) && !refPending && reqValid;
    ctl.takeRef  = (state == ST_IDLE) && refPending;
    ctl.selCol   = (state == ST_COL);
    ctl.selRef   = (state == ST_REF);
    ctl.stepRow  = (state == ST_REF) && phaseEnd;
  end

  assign busy      = (state != ST_IDLE);
  assign done      = doneReg;
  assign rowStrobe = (state == ST_ROW) || (state == ST_COL) || (state == ST_REF);
  assign colStrobe = (state == ST_COL);
  assign chipSel   = rowStrobe;
  assign memWrite  = ((state == ST_ROW) || (state == ST_COL)) && heldWrite;
endmodule

// File: rtl/dram_access_ctrl.sv
module dram_access_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W        = 12,
  parameter int COL_W        = 9,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 1,
  parameter int T_REF        = 3,
  parameter int CLK_KHZ      = 125000,
  parameter int RETAIN_MS    = 64,
  parameter int REF_INTERVAL = (RETAIN_MS * CLK_KHZ) >> ROW_W,
  localparam int ADDR_W      = ROW_W + COL_W,
  localparam int MUX_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              busy,
  output logic              done,
  output logic [MUX_W-1:0]  memAddr,
  output logic              rowStrobe,
  output logic              colStrobe,
  output logic              memWrite,
  output logic              chipSel
);
  pathCtl_t ctl;
  logic     refPending;
  logic     heldWrite;

  dram_ctrl_fsm #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_REF(T_REF)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .refPending(refPending),
    .heldWrite(heldWrite), .ctl(ctl), .busy(busy), .done(done),
    .rowStrobe(rowStrobe), .colStrobe(colStrobe), .memWrite(memWrite),
    .chipSel(chipSel)
  );

  dram_ctrl_path #(
    .ROW_W(ROW_W), .COL_W(COL_W), .REF_INTERVAL(REF_INTERVAL)
  ) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .memAddr(memAddr), .heldWrite(heldWrite), .refPending(refPending)
  );
endmodule

// File: rtl/dram_ctrl_chk.sv
module dram_ctrl_chk #(
  parameter int MUX_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             done,
  input logic [MUX_W-1:0] memAddr,
  input logic             rowStrobe,
  input logic             colStrobe,
  input logic             memWrite,
  input logic             chipSel
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!rowStrobe && !colStrobe && !chipSel && !memWrite && !done));

  p_col_after_row_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(colStrobe) |-> $past(rowStrobe));

  p_col_inside_row_r4: assert property (@(posedge clk) disable iff (!rstN)
    colStrobe |-> (rowStrobe && chipSel));

  p_col_addr_steady_r4: assert property (@(posedge clk) disable iff (!rstN)
    (colStrobe && $past(colStrobe)) |-> $stable(memAddr));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && !rowStrobe && !colStrobe));

  p_write_steady_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rowStrobe && $past(rowStrobe)) |-> $stable(memWrite));
endmodule

bind dram_access_ctrl dram_ctrl_chk #(.MUX_W(MUX_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .memAddr(memAddr),
  .rowStrobe(rowStrobe), .colStrobe(colStrobe), .memWrite(memWrite),
  .chipSel(chipSel)
);

// File: tb/sim_dram_access_ctrl.sv
module sim_dram_access_ctrl;
  localparam int ROW_W = 4;
  localparam int COL_W = 3;
  localparam int T_RCD = 2;
  localparam int T_CAS = 2;
  localparam int T_RP  = 1;
  localparam int T_REF = 3;
  localparam int IVL   = 100;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MUX_W  = 4;
  localparam int NROWS  = 1 << ROW_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic busy, done, rowStrobe, colStrobe, memWrite, chipSel;
  logic [MUX_W-1:0] memAddr;

  int passCnt = 0;
  int checkCnt = 0;
  int lastRow = 0;

  always #4 clk = ~clk;

  dram_access_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RP(T_RP), .T_REF(T_REF), .REF_INTERVAL(IVL)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .busy(busy), .done(done), .memAddr(memAddr),
    .rowStrobe(rowStrobe), .colStrobe(colStrobe), .memWrite(memWrite),
    .chipSel(chipSel)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
  endtask

  function automatic int pack(input logic a, input logic b, input logic c, input logic d);
    return {28'd0, a, b, c, d};
  endfunction

  // Wait for a refresh to start, record its row, return once idle again
  task automatic syncRefresh();
    while (!busy) @(negedge clk);
    lastRow = int'(memAddr);
    while (busy) @(negedge clk);
  endtask

  // Called at a falling edge with reqValid high and the block idle
  task automatic runAccess(input logic [ADDR_W-1:0] a, input logic wr, input string tag);
    int rowExp = int'(a[ADDR_W-1:COL_W]);
    int colExp = int'(a[COL_W-1:0]);
    for (int i = 0; i < T_RCD; i++) begin
      @(negedge clk);
      if (i == 0) reqValid = 1'b0;
      chk(busy && rowStrobe && !colStrobe && chipSel && !done,
          {tag, " R3 row strobes"}, pack(rowStrobe, colStrobe, chipSel, done), 4'b1010);
      chk(int'(memAddr) == rowExp, {tag, " R3 row addr"}, int'(memAddr), rowExp);
      chk(memWrite == wr, {tag, " R6 write row"}, int'(memWrite), int'(wr));
    end
    for (int i = 0; i < T_CAS; i++) begin
      @(negedge clk);
      chk(rowStrobe && colStrobe && chipSel && !done,
          {tag, " R4 col strobes"}, pack(rowStrobe, colStrobe, chipSel, done), 4'b1110);
      chk(int'(memAddr) == colExp, {tag, " R4 col addr"}, int'(memAddr), colExp);
      chk(memWrite == wr, {tag, " R6 write col"}, int'(memWrite), int'(wr));
    end
    @(negedge clk);
    chk(done && busy && !rowStrobe && !colStrobe && !memWrite,
        {tag, " R5 done cycle"}, pack(done, busy, rowStrobe, colStrobe), 4'b1100);
    for (int i = 1; i < T_RP; i++) begin
      @(negedge clk);
      chk(busy && !done, {tag, " R5 precharge"}, pack(1'b0, 1'b0, busy, done), 2);
    end
    @(negedge clk);
    chk(!busy && !done, {tag, " R5 idle after"}, pack(1'b0, 1'b0, busy, done), 0);
  endtask

  task automatic checkRefreshStart(input int expRow, input string tag);
    chk(busy && rowStrobe && !colStrobe && chipSel,
        {tag, " R7 refresh strobes"}, pack(busy, rowStrobe, colStrobe, chipSel), 4'b1101);
    chk(int'(memAddr) == expRow, {tag, " R8 refresh row"}, int'(memAddr), expRow);
  endtask

  task automatic tReset();
    @(negedge clk);
    chk(!busy && !rowStrobe && !colStrobe && !done, "R1 in reset",
        pack(busy, rowStrobe, colStrobe, done), 0);
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!busy && !rowStrobe && !colStrobe && !chipSel && !memWrite && !done,
          "R1 after reset", pack(busy, rowStrobe, colStrobe, chipSel), 0);
    end
  endtask

  // R7/R8: interval, shape and row sequence including wrap
  task automatic tRefreshSeq();
    int expRow = 0;
    while (!busy) @(negedge clk);
    for (int r = 0; r <= NROWS; r++) begin
      int gap = 0;
      for (int i = 0; i < T_REF; i++) begin
        checkRefreshStart(expRow, "seq");
        chk(!memWrite && !done, "R7 no write/done in refresh",
            pack(1'b0, 1'b0, memWrite, done), 0);
        @(negedge clk); gap++;
      end
      for (int i = 0; i < T_RP; i++) begin
        chk(busy && !rowStrobe && !done, "R7 refresh precharge",
            pack(1'b0, busy, rowStrobe, done), 4);
        @(negedge clk); gap++;
      end
      while (!busy) begin @(negedge clk); gap++; end
      chk(gap == IVL, "R7 refresh interval", gap, IVL);
      expRow = (expRow + 1) % NROWS;
    end
  endtask

  task automatic tAccess(input logic [ADDR_W-1:0] a, input logic wr, input string tag);
    syncRefresh();
    reqAddr = a; reqWrite = wr; reqValid = 1'b1;
    runAccess(a, wr, tag);
  endtask

  // R2: request pulse during busy is dropped
  task automatic tIgnore();
    syncRefresh();
    reqAddr = 7'h5A; reqWrite = 1'b1; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(int'(memAddr) == 4'hB, "R2 first row", int'(memAddr), 4'hB);
    reqAddr = 7'h27; reqWrite = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(int'(memAddr) == 4'hB && memWrite, "R2 row kept", int'(memAddr), 4'hB);
    @(negedge clk);
    chk(int'(memAddr) == 2 && colStrobe, "R2 col kept", int'(memAddr), 2);
    while (busy) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!busy && !rowStrobe, "R2 no second access", pack(1'b0, 1'b0, busy, rowStrobe), 0);
    end
  endtask

  // R9: refresh and request arrive together
  task automatic tPriority();
    syncRefresh();
    repeat (IVL - 1 - (T_REF + T_RP)) @(negedge clk);
    reqAddr = 7'h6C; reqWrite = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    checkRefreshStart((lastRow + 1) % NROWS, "R9 refresh first");
    chk(reqValid && !colStrobe, "R9 request waits", int'(colStrobe), 0);
    repeat (T_REF + T_RP - 1) @(negedge clk);
    while (busy) @(negedge clk);
    runAccess(7'h6C, 1'b0, "R9 deferred access");
  endtask

  // R10: refresh due mid-access runs before the next request
  task automatic tHeld();
    int refRow;
    syncRefresh();
    refRow = (lastRow + 1) % NROWS;
    repeat (IVL - 3 - (T_REF + T_RP)) @(negedge clk);
    reqAddr = 7'h13; reqWrite = 1'b1; reqValid = 1'b1;
    runAccess(7'h13, 1'b1, "R10 access");
    reqAddr = 7'h71; reqWrite = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    checkRefreshStart(refRow, "R10 held refresh");
    while (busy) @(negedge clk);
    runAccess(7'h71, 1'b0, "R10 later access");
  endtask

  initial begin
    tReset();
    tRefreshSeq();
    tAccess(7'h00, 1'b0, "read zero");
    tAccess(7'h7F, 1'b1, "write ones");
    tAccess(7'h4D, 1'b0, "read mixed");
    tAccess(7'h32, 1'b1, "write mixed");
    tIgnore();
    tPriority();
    tHeld();
    $display("%0d/%0d checks passed", passCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checkCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", passCnt, checkCnt);
    $finish;
  end
endmodule